// File: doc/BRIEF.md
# Shared-Memory Neighbour Link with Flag Handshake

This block joins two neighbouring processing units through a small true dual-port RAM and a bank of event flags. Each side has its own port, with an address, a read strobe, a write strobe and write data. Both ports work in the same cycle and need no arbitration. Both ports use one clock. Reads are synchronous: the data arrives one cycle after the read strobe, and the read register keeps its value while no read is issued.

The two sides share no arbiter. They agree who owns which buffer through flag lines that point one way. Side A owns a set of flag registers that side B sees. Side B owns a matching set that side A sees. Each side sets or clears its own flags with bit masks, for events such as "buffer filled" or "buffer released". The hardware still watches for the two unsafe cases. When both sides write the same address, port A's data is stored and a sticky error flag is raised. When one side reads an address the other side writes in the same cycle, the read returns the old contents and a one-cycle hazard pulse is reported.

Top module: `pu_link`

## Requirements
- R1: In one cycle, both ports may write, or read, different addresses, and each access completes with no effect on the other port.
- R2: Read data appears on a port's read-data output in the cycle after its read strobe. While the read strobe is low, the read-data output holds its last value.
- R3: If a word is read and written in the same cycle, by the same port or by the other port, the read returns the contents from before the write.
- R4: When both ports write the same address in the same cycle, the word afterwards holds port A's data.
- R5: A same-address dual write raises `wrCollErr` on the next cycle. The flag stays high until reset.
- R6: `rwHazard` is high for exactly the cycle after a cycle in which one port writes an address that the other port reads. It is low after any other cycle.
- R7: Bit i of a side's set mask makes its outgoing flag i equal 1. Bit i of its clear mask makes the flag equal 0. If both bits are given, set wins. The other side sees the new value one cycle after the command.
- R8: A flag bit keeps its value in every cycle in which its owner gives neither a set nor a clear for that bit.
- R9: While reset is asserted, both read-data outputs, all flags, `wrCollErr` and `rwHazard` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rstN | input | 1 | Asynchronous reset, active low |
| aAddr | input | ADDR_W | Port A word address |
| aRdEn | input | 1 | Port A read strobe |
| aWrEn | input | 1 | Port A write strobe |
| aWrData | input | DATA_W | Port A write data |
| aRdData | output | DATA_W | Port A registered read data |
| bAddr | input | ADDR_W | Port B word address |
| bRdEn | input | 1 | Port B read strobe |
| bWrEn | input | 1 | Port B write strobe |
| bWrData | input | DATA_W | Port B write data |
| bRdData | output | DATA_W | Port B registered read data |
| aSyncSet | input | SYNC_N | Side A mask that sets its outgoing flags |
| aSyncClr | input | SYNC_N | Side A mask that clears its outgoing flags |
| aSyncIn | output | SYNC_N | Flags owned by side B, as seen by side A |
| bSyncSet | input | SYNC_N | Side B mask that sets its outgoing flags |
| bSyncClr | input | SYNC_N | Side B mask that clears its outgoing flags |
| bSyncIn | output | SYNC_N | Flags owned by side A, as seen by side B |
| wrCollErr | output | 1 | Sticky flag for a same-address dual write |
| rwHazard | output | 1 | One-cycle pulse after a same-address read/write overlap |

## Verification
Collisions only happen when both ports choose the same address in the same cycle, and a wide address space almost never does that at random. The random phase therefore limits both ports to a few low addresses and turns the strobes on independently. This produces dual writes, cross read/write overlaps and same-port read-while-write cases often. Directed steps first place each collision case on its own, before the sticky error flag is set. This lets R5 and R6 be seen rising from a clean state.

// File: rtl/pu_link_pkg.sv
package pu_link_pkg;
  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic wrA;   // commit port A write
    logic wrB;   // commit port B write (dropped when A writes the same word)
    logic rdA;   // load port A read register
    logic rdB;   // load port B read register
  } link_strobe_t;
endpackage

// File: rtl/pu_link_ctrl.sv
module pu_link_ctrl
  import pu_link_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              aRdEn,
  input  logic              aWrEn,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic              bRdEn,
  input  logic              bWrEn,
  output link_strobe_t      strobe,
  output logic              wrCollErr,
  output logic              rwHazard
);
  logic sameAddr;
  logic dualWrite;
  logic crossHit;
  logic collReg;
  logic hazReg;

  assign sameAddr  = (aAddr == bAddr);
  assign dualWrite = aWrEn && bWrEn && sameAddr;
  assign crossHit  = sameAddr && ((aWrEn && bRdEn) || (bWrEn && aRdEn));

  always_comb begin
    strobe.wrA = aWrEn;
    strobe.wrB = bWrEn && !dualWrite;  // port A has priority
    strobe.rdA = aRdEn;
    strobe.rdB = bRdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      collReg <= 1'b0;
      hazReg  <= 1'b0;
    end else begin
      if (dualWrite) collReg <= 1'b1;
      hazReg <= crossHit;
    end
  end

  assign wrCollErr = collReg;
  assign rwHazard  = hazReg;
endmodule

// File: rtl/pu_link_dp.sv
module pu_link_dp
  import pu_link_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int SYNC_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  link_strobe_t      strobe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] aWrData,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] aRdData,
  output logic [DATA_W-1:0] bRdData,
  input  logic [SYNC_N-1:0] aSyncSet,
  input  logic [SYNC_N-1:0] aSyncClr,
  input  logic [SYNC_N-1:0] bSyncSet,
  input  logic [SYNC_N-1:0] bSyncClr,
  output logic [SYNC_N-1:0] aSyncOwn,
  output logic [SYNC_N-1:0] bSyncOwn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Write port: the control drops B's write on a same-address clash
  always_ff @(posedge clk) begin
    if (strobe.wrA) mem[aAddr] <= aWrData;
    if (strobe.wrB) mem[bAddr] <= bWrData;
  end

  // Registered reads observe the array before this edge's writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aRdData <= '0;
      bRdData <= '0;
    end else begin
      if (strobe.rdA) aRdData <= mem[aAddr];
      if (strobe.rdB) bRdData <= mem[bAddr];
    end
  end

  // One set/clear register per flag line and direction
  for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aSyncOwn[i] <= 1'b0;
        bSyncOwn[i] <= 1'b0;
      end else begin
        if (aSyncSet[i])      aSyncOwn[i] <= 1'b1;
        else if (aSyncClr[i]) aSyncOwn[i] <= 1'b0;
        if (bSyncSet[i])      bSyncOwn[i] <= 1'b1;
        else if (bSyncClr[i]) bSyncOwn[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pu_link.sv
module pu_link
  import pu_link_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int SYNC_N = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              aRdEn,
  input  logic              aWrEn,
  input  logic [DATA_W-1:0] aWrData,
  output logic [DATA_W-1:0] aRdData,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic              bRdEn,
  input  logic              bWrEn,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] bRdData,
  input  logic [SYNC_N-1:0] aSyncSet,
  input  logic [SYNC_N-1:0] aSyncClr,
  output logic [SYNC_N-1:0] aSyncIn,
  input  logic [SYNC_N-1:0] bSyncSet,
  input  logic [SYNC_N-1:0] bSyncClr,
  output logic [SYNC_N-1:0] bSyncIn,
  output logic              wrCollErr,
  output logic              rwHazard
);
  link_strobe_t      strobe;
  logic [SYNC_N-1:0] aSyncOwn;
  logic [SYNC_N-1:0] bSyncOwn;

  pu_link_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .aAddr(aAddr), .aRdEn(aRdEn), .aWrEn(aWrEn),
    .bAddr(bAddr), .bRdEn(bRdEn), .bWrEn(bWrEn),
    .strobe(strobe), .wrCollErr(wrCollErr), .rwHazard(rwHazard)
  );

  pu_link_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aAddr(aAddr), .bAddr(bAddr), .aWrData(aWrData), .bWrData(bWrData),
    .aRdData(aRdData), .bRdData(bRdData),
    .aSyncSet(aSyncSet), .aSyncClr(aSyncClr),
    .bSyncSet(bSyncSet), .bSyncClr(bSyncClr),
    .aSyncOwn(aSyncOwn), .bSyncOwn(bSyncOwn)
  );

  // Each side sees the flags its neighbour owns
  assign aSyncIn = bSyncOwn;
  assign bSyncIn = aSyncOwn;
endmodule

// File: rtl/pu_link_chk.sv
module pu_link_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int SYNC_N = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] aAddr,
  input logic [ADDR_W-1:0] bAddr,
  input logic              aRdEn,
  input logic              bRdEn,
  input logic              aWrEn,
  input logic              bWrEn,
  input logic [DATA_W-1:0] aRdData,
  input logic [SYNC_N-1:0] aSyncSet,
  input logic [SYNC_N-1:0] aSyncClr,
  input logic [SYNC_N-1:0] bSyncIn,
  input logic              wrCollErr,
  input logic              rwHazard
);
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !aRdEn |=> $stable(aRdData));

  p_coll_raise_r5: assert property (@(posedge clk) disable iff (!rstN)
    (aWrEn && bWrEn && aAddr == bAddr) |=> wrCollErr);

  p_coll_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrCollErr |=> wrCollErr);

  p_haz_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    (aAddr == bAddr && ((aWrEn && bRdEn) || (bWrEn && aRdEn))) |=> rwHazard);

  p_haz_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(aAddr == bAddr && ((aWrEn && bRdEn) || (bWrEn && aRdEn))) |=> !rwHazard);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (aSyncSet != '0) |=> ((bSyncIn & $past(aSyncSet)) == $past(aSyncSet)));

  p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (aSyncSet == '0 && aSyncClr == '0) |=> $stable(bSyncIn));

  always_comb begin
    if (!rstN) begin
      p_reset_r9: assert (wrCollErr == 1'b0 && rwHazard == 1'b0);
    end
  end
endmodule

bind pu_link pu_link_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_chk (
  .clk(clk), .rstN(rstN), .aAddr(aAddr), .bAddr(bAddr),
  .aRdEn(aRdEn), .bRdEn(bRdEn), .aWrEn(aWrEn), .bWrEn(bWrEn),
  .aRdData(aRdData), .aSyncSet(aSyncSet), .aSyncClr(aSyncClr),
  .bSyncIn(bSyncIn), .wrCollErr(wrCollErr), .rwHazard(rwHazard)
);

// File: tb/pu_link_test.sv
module pu_link_test;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 16;
  localparam int SYNC_N = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] aAddr, bAddr;
  logic aRdEn, aWrEn, bRdEn, bWrEn;
  logic [DATA_W-1:0] aWrData, bWrData, aRdData, bRdData;
  logic [SYNC_N-1:0] aSyncSet, aSyncClr, bSyncSet, bSyncClr, aSyncIn, bSyncIn;
  logic wrCollErr, rwHazard;

  always #4 clk = ~clk;  // 125 MHz

  pu_link #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) uut (
    .clk(clk), .rstN(rstN),
    .aAddr(aAddr), .aRdEn(aRdEn), .aWrEn(aWrEn), .aWrData(aWrData), .aRdData(aRdData),
    .bAddr(bAddr), .bRdEn(bRdEn), .bWrEn(bWrEn), .bWrData(bWrData), .bRdData(bRdData),
    .aSyncSet(aSyncSet), .aSyncClr(aSyncClr), .aSyncIn(aSyncIn),
    .bSyncSet(bSyncSet), .bSyncClr(bSyncClr), .bSyncIn(bSyncIn),
    .wrCollErr(wrCollErr), .rwHazard(rwHazard)
  );

  int nCmp = 0;
  int nBad = 0;

  // Reference state built from the requirements
  logic [DATA_W-1:0] mMem [DEPTH];
  logic [DATA_W-1:0] expA = '0, expB = '0;
  logic [SYNC_N-1:0] expAIn = '0, expBIn = '0;
  logic expColl = 1'b0, expHaz = 1'b0;

  function automatic logic [SYNC_N-1:0] nextFlags(logic [SYNC_N-1:0] cur,
      logic [SYNC_N-1:0] setM, logic [SYNC_N-1:0] clrM);
    return (cur & ~clrM) | setM;  // set wins over clear
  endfunction

  function automatic logic crossHit(logic [ADDR_W-1:0] x, logic [ADDR_W-1:0] y,
      logic xw, logic xr, logic yw, logic yr);
    return (x == y) && ((xw && yr) || (yw && xr));
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    aRdEn = 0; aWrEn = 0; bRdEn = 0; bWrEn = 0;
    aAddr = '0; bAddr = '0; aWrData = '0; bWrData = '0;
    aSyncSet = '0; aSyncClr = '0; bSyncSet = '0; bSyncClr = '0;
  endtask

  // Model one clock with the inputs now driven, then compare at the next negedge
  task automatic step(string tag);
    expHaz = crossHit(aAddr, bAddr, aWrEn, aRdEn, bWrEn, bRdEn);
    if (aRdEn) expA = mMem[aAddr];
    if (bRdEn) expB = mMem[bAddr];
    if (aWrEn && bWrEn && aAddr == bAddr) expColl = 1'b1;
    expBIn = nextFlags(expBIn, aSyncSet, aSyncClr);
    expAIn = nextFlags(expAIn, bSyncSet, bSyncClr);
    if (bWrEn) mMem[bAddr] = bWrData;
    if (aWrEn) mMem[aAddr] = aWrData;  // port A wins
    @(posedge clk);
    @(negedge clk);
    chk(tag, "aRdData", 32'(aRdData), 32'(expA));
    chk(tag, "bRdData", 32'(bRdData), 32'(expB));
    chk("R7/R8", "aSyncIn", 32'(aSyncIn), 32'(expAIn));
    chk("R7/R8", "bSyncIn", 32'(bSyncIn), 32'(expBIn));
    chk("R5", "wrCollErr", 32'(wrCollErr), 32'(expColl));
    chk("R6", "rwHazard", 32'(rwHazard), 32'(expHaz));
  endtask

  initial begin
    #(8 * 150000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "aRdData", 32'(aRdData), 0);
    chk("R9", "bRdData", 32'(bRdData), 0);
    chk("R9", "flags", 32'({aSyncIn, bSyncIn}), 0);
    chk("R9", "errors", 32'({wrCollErr, rwHazard}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Fill the array from port A
    for (int i = 0; i < DEPTH; i++) begin
      idle(); aWrEn = 1; aAddr = ADDR_W'(i); aWrData = DATA_W'(16'h1000 + i);
      step("R1");
    end

    // R1: both ports write different words, then read them back crosswise
    idle(); aWrEn = 1; aAddr = 6'd10; aWrData = 16'hAAAA;
    bWrEn = 1; bAddr = 6'd11; bWrData = 16'hBBBB;
    step("R1");
    idle(); aRdEn = 1; aAddr = 6'd11; bRdEn = 1; bAddr = 6'd10;
    step("R1");
    // R2: data held while read strobes are low
    idle(); step("R2");
    step("R2");
    // R3: B reads word A writes in same cycle, old data and hazard pulse (R6)
    idle(); aWrEn = 1; aAddr = 6'd20; aWrData = 16'hC0DE;
    bRdEn = 1; bAddr = 6'd20;
    step("R3");
    // R3: same-port read while writing returns old data
    idle(); bWrEn = 1; bRdEn = 1; bAddr = 6'd21; bWrData = 16'h7777;
    step("R3");
    idle(); bRdEn = 1; bAddr = 6'd21; step("R3");
    // R4/R5: dual write to one address
    idle(); aWrEn = 1; bWrEn = 1; aAddr = 6'd30; bAddr = 6'd30;
    aWrData = 16'h5A5A; bWrData = 16'hA5A5;
    step("R4");
    idle(); aRdEn = 1; bRdEn = 1; aAddr = 6'd30; bAddr = 6'd30;
    step("R4");
    // R7: set and clear together, set wins; then clear alone
    idle(); aSyncSet = 4'b0011; aSyncClr = 4'b0001; bSyncSet = 4'b1000;
    step("R7");
    idle(); aSyncClr = 4'b0010; step("R7");
    idle(); step("R8");

    // Constrained random: narrow address range to force collisions
    for (int n = 0; n < 3000; n++) begin
      idle();
      aAddr = ADDR_W'($urandom % 8); bAddr = ADDR_W'($urandom % 8);
      aRdEn = 1'($urandom); aWrEn = 1'($urandom);
      bRdEn = 1'($urandom); bWrEn = 1'($urandom);
      aWrData = DATA_W'($urandom); bWrData = DATA_W'($urandom);
      aSyncSet = SYNC_N'($urandom & $urandom); aSyncClr = SYNC_N'($urandom & $urandom);
      bSyncSet = SYNC_N'($urandom & $urandom); bSyncClr = SYNC_N'($urandom & $urandom);
      step("R2");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule